// File: doc/BRIEF.md
# Byte-strobe SRAM bus cycle generator

This block turns one internal access request into one or more external bus cycles for asynchronous static RAM with a 16-bit data path. The requester presents an address, a size (byte, word or longword), a direction and write data. The block then drives the address, the write data with its output enable, a read strobe, a read/write line and two lane strobes. At the end it returns a one-tick done pulse, together with the assembled read data.

The address space is split into eight areas, selected by the top address bits. Each area has its own configuration bits: lane-select enable, 16-bit width, burst-ROM type, multiplexed type and early read negation. When lane-select mode is in effect, the two lane strobes become upper-byte and lower-byte selects that assert on reads as well as writes. In this mode the read/write line acts as the RAM's write enable, and the read strobe always ends half a bus clock early.

The block runs on a clock at twice the bus rate, so one tick is half a bus clock. A basic cycle is four ticks long. Each wait state (0 to 7, sampled with the request) adds two ticks to the middle of the cycle.

Top module: `sram_bytesel_bus`

## Requirements
- R1: The area is address bits [AW-1:AW-3]. Lane-select mode applies only when the area's lane-select bit is 1, its width bit is 1 (16-bit), its burst bit is 0 and its multiplexed bit is 0. In every other case the area uses basic timing.
- R2: In lane-select mode, the strobe of each lane the beat uses is low from tick 1 through the last tick of the beat, on both reads and writes.
- R3: In basic mode, the lane strobes (active low, hstb = upper lane D15..D8, lstb = lower lane D7..D0) are low only on write beats, from tick 1 through tick L-2. They stay high on reads.
- R4: bus_rw_n is low for every tick of every write beat and high at all other times.
- R5: On a read beat, bus_rd_n goes low at tick 1. It is last low at tick L-2 in lane-select mode, whatever the early bit is. In basic mode it is last low at tick L-2 when the area's early bit is 1 and at tick L-1 when it is 0. It is never low during a write.
- R6: In 16-bit areas (size code 0 = byte, 1 = word, 2 or 3 = longword), a byte uses the upper lane at an even address and the lower lane at an odd address. A word or longword uses both lanes with address bit 0 forced to 0. A longword takes two beats, at base then base+2, with the upper 16 bits first.
- R7: In 8-bit areas, each beat moves one byte on the upper lane only. A request takes as many beats as it has bytes, at incrementing addresses, most significant byte first.
- R8: Every beat lasts L = 4 + 2*W ticks, where W is the wait count sampled when the request is accepted.
- R9: Read data is sampled at the last tick bus_rd_n is low. It is assembled most significant byte first and zero-extended in rdata, which is valid when done pulses.
- R10: bus_doe is high on every tick where bus_rw_n is low and for one tick after that, and low otherwise. bus_dout carries the beat's write data on the lanes in use.
- R11: busy rises in the tick after a request is accepted. done is a one-tick pulse in the tick after the final beat, when busy has already fallen. A request presented while busy is ignored.
- R12: After reset the block is idle: busy, done and bus_doe are low, and all strobes and bus_rw_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two ticks per bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present (taken when idle) |
| req_addr | input | AW | Request byte address |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data, right-aligned |
| wait_states | input | WAITW | Wait states for this request |
| cfg_lanesel | input | NAREA | Per-area lane-select enable |
| cfg_wide | input | NAREA | Per-area 16-bit width |
| cfg_burst | input | NAREA | Per-area burst ROM type |
| cfg_muxed | input | NAREA | Per-area multiplexed type |
| cfg_rd_early | input | NAREA | Per-area early read negation in basic mode |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-tick completion pulse |
| rdata | output | 32 | Assembled read data |
| bus_addr | output | AW | External address |
| bus_dout | output | 16 | Data driven to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Data read from the bus |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_rw_n | output | 1 | Read/write line (write enable when low) |
| bus_hstb_n | output | 1 | Upper-lane strobe or select, active low |
| bus_lstb_n | output | 1 | Lower-lane strobe or select, active low |

## Verification
The assertions check, on every tick, the relations between strobes that hold in any cycle. These are: quiet idle levels, no read strobe during a write, no lane strobes on basic-mode reads, lane selects present whenever the read strobe is low in lane-select mode, at most one lane for a byte, no lower lane in 8-bit areas, the output-enable hold and the shape of the done pulse. Only the bench scenarios can show the exact tick positions of each edge for a given wait count, the lane and address sequence of split accesses, the data that was sampled and its byte order, and that the burst and multiplexed areas fall back to basic timing.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LNG2 = 2'b11
    } sbus_size_e;

    function automatic logic [2:0] size_bytes(input sbus_size_e sz);
        case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_WORD: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sbus_area_mode.sv
module sbus_area_mode #(
    parameter int NAREA = 8,
    parameter int ABITS = $clog2(NAREA)
) (
    input  logic [ABITS-1:0] area,
    input  logic [NAREA-1:0] cfg_lanesel,
    input  logic [NAREA-1:0] cfg_wide,
    input  logic [NAREA-1:0] cfg_burst,
    input  logic [NAREA-1:0] cfg_muxed,
    input  logic [NAREA-1:0] cfg_rd_early,
    output logic             lanesel_mode,
    output logic             wide,
    output logic             rd_early
);

    logic [NAREA-1:0] eff_sel;

    // Lane-select only survives in plain 16-bit areas.
    for (genvar i = 0; i < NAREA; i++) begin : g_area
        assign eff_sel[i] = cfg_lanesel[i] & cfg_wide[i] & ~cfg_burst[i] & ~cfg_muxed[i];
    end

    assign lanesel_mode = eff_sel[area];
    assign wide         = cfg_wide[area];
    assign rd_early     = cfg_rd_early[area];

endmodule

// File: rtl/sbus_beat_plan.sv
module sbus_beat_plan
    import sbus_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic             wide,
    input  sbus_size_e       size,
    input  logic [AW-1:0]    addr,
    input  logic [31:0]      wdata,
    input  logic [1:0]       beat,
    input  logic [15:0]      din,
    input  logic [31:0]      acc,
    output logic [AW-1:0]    beat_addr,
    output logic             lane_hi,
    output logic             lane_lo,
    output logic [15:0]      dout,
    output logic [1:0]       last_beat,
    output logic [31:0]      acc_next
);

    logic [AW-1:0] base;
    logic [2:0]    nbytes;
    logic [1:0]    sel;
    logic [7:0]    nbyte;

    always_comb begin
        nbytes    = size_bytes(size);
        base      = (size == SZ_BYTE) ? addr : {addr[AW-1:1], 1'b0};
        sel       = 2'd0;
        nbyte     = 8'd0;
        beat_addr = base;
        lane_hi   = 1'b1;
        lane_lo   = 1'b1;
        dout      = wdata[15:0];
        last_beat = 2'd0;
        acc_next  = {acc[15:0], din};
        if (wide) begin
            beat_addr = base + AW'({beat, 1'b0});
            case (size)
                SZ_BYTE: begin
                    lane_hi  = ~addr[0];
                    lane_lo  = addr[0];
                    dout     = {wdata[7:0], wdata[7:0]};
                    acc_next = {acc[23:0], addr[0] ? din[7:0] : din[15:8]};
                end
                SZ_WORD: begin
                    dout = wdata[15:0];
                end
                default: begin
                    last_beat = 2'd1;
                    dout      = beat[0] ? wdata[15:0] : wdata[31:16];
                end
            endcase
        end else begin
            // 8-bit device on the upper lane: one byte per beat.
            last_beat = 2'(nbytes - 3'd1);
            beat_addr = base + AW'(beat);
            sel       = last_beat - beat;
            nbyte     = wdata[{sel, 3'b000} +: 8];
            lane_hi   = 1'b1;
            lane_lo   = 1'b0;
            dout      = {nbyte, nbyte};
            acc_next  = {acc[23:0], din[15:8]};
        end
    end

endmodule

// File: rtl/sbus_strobe_gen.sv
module sbus_strobe_gen #(
    parameter int TW = 5
) (
    input  logic          active,
    input  logic [TW-1:0] tick,
    input  logic [TW-1:0] len_m1,
    input  logic          write,
    input  logic          lanesel_mode,
    input  logic          rd_early,
    input  logic          lane_hi,
    input  logic          lane_lo,
    output logic          rd_n,
    output logic          rw_n,
    output logic          hstb_n,
    output logic          lstb_n,
    output logic          rw_low,
    output logic          cap
);

    logic [TW-1:0] rd_last;
    logic          rd_low;
    logic          win;

    always_comb begin
        // Lane-select mode always ends the read half a bus clock early.
        rd_last = (lanesel_mode || rd_early) ? (len_m1 - TW'(1)) : len_m1;
        rd_low  = active && !write && (tick != '0) && (tick <= rd_last);
        rw_low  = active && write;
        if (lanesel_mode) begin
            win = active && (tick != '0);
        end else begin
            win = active && write && (tick != '0) && (tick < len_m1);
        end
        rd_n   = ~rd_low;
        rw_n   = ~rw_low;
        hstb_n = ~(win && lane_hi);
        lstb_n = ~(win && lane_lo);
        cap    = active && !write && (tick == rd_last);
    end

endmodule

// File: rtl/sram_bytesel_bus.sv
module sram_bytesel_bus
    import sbus_pkg::*;
#(
    parameter int AW       = 24,
    parameter int NAREA    = 8,
    parameter int WAITW    = 3,
    parameter int WAIT_MAX = (1 << WAITW) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic [WAITW-1:0]  wait_states,
    input  logic [NAREA-1:0]  cfg_lanesel,
    input  logic [NAREA-1:0]  cfg_wide,
    input  logic [NAREA-1:0]  cfg_burst,
    input  logic [NAREA-1:0]  cfg_muxed,
    input  logic [NAREA-1:0]  cfg_rd_early,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic [AW-1:0]     bus_addr,
    output logic [15:0]       bus_dout,
    output logic              bus_doe,
    input  logic [15:0]       bus_din,
    output logic              bus_rd_n,
    output logic              bus_rw_n,
    output logic              bus_hstb_n,
    output logic              bus_lstb_n
);

    localparam int ABITS = $clog2(NAREA);
    localparam int TW    = $clog2(4 + 2 * WAIT_MAX);

    typedef struct packed {
        logic             active;
        logic             done;
        logic             hold;
        logic [TW-1:0]    tick;
        logic [1:0]       beat;
        logic [AW-1:0]    addr;
        sbus_size_e       size;
        logic             write;
        logic [31:0]      wdata;
        logic [WAITW-1:0] wait_n;
        logic             lanesel;
        logic             wide;
        logic             rd_early;
        logic [31:0]      acc;
    } st_t;

    st_t st_q, st_d;

    logic          req_lanesel, req_wide, req_rd_early;
    logic [AW-1:0] beat_addr;
    logic          lane_hi, lane_lo;
    logic [15:0]   beat_dout;
    logic [1:0]    last_beat;
    logic [31:0]   acc_next;
    logic [TW-1:0] len_m1;
    logic          rw_low, cap;

    sbus_area_mode #(.NAREA(NAREA), .ABITS(ABITS)) u_area (
        .area         (req_addr[AW-1 -: ABITS]),
        .cfg_lanesel  (cfg_lanesel),
        .cfg_wide     (cfg_wide),
        .cfg_burst    (cfg_burst),
        .cfg_muxed    (cfg_muxed),
        .cfg_rd_early (cfg_rd_early),
        .lanesel_mode (req_lanesel),
        .wide         (req_wide),
        .rd_early     (req_rd_early)
    );

    sbus_beat_plan #(.AW(AW)) u_plan (
        .wide      (st_q.wide),
        .size      (st_q.size),
        .addr      (st_q.addr),
        .wdata     (st_q.wdata),
        .beat      (st_q.beat),
        .din       (bus_din),
        .acc       (st_q.acc),
        .beat_addr (beat_addr),
        .lane_hi   (lane_hi),
        .lane_lo   (lane_lo),
        .dout      (beat_dout),
        .last_beat (last_beat),
        .acc_next  (acc_next)
    );

    assign len_m1 = TW'(3) + TW'({st_q.wait_n, 1'b0});

    sbus_strobe_gen #(.TW(TW)) u_strb (
        .active       (st_q.active),
        .tick         (st_q.tick),
        .len_m1       (len_m1),
        .write        (st_q.write),
        .lanesel_mode (st_q.lanesel),
        .rd_early     (st_q.rd_early),
        .lane_hi      (lane_hi),
        .lane_lo      (lane_lo),
        .rd_n         (bus_rd_n),
        .rw_n         (bus_rw_n),
        .hstb_n       (bus_hstb_n),
        .lstb_n       (bus_lstb_n),
        .rw_low       (rw_low),
        .cap          (cap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.hold = rw_low;
        if (!st_q.active) begin
            if (req_valid) begin
                st_d.active   = 1'b1;
                st_d.tick     = '0;
                st_d.beat     = 2'd0;
                st_d.addr     = req_addr;
                st_d.size     = sbus_size_e'(req_size);
                st_d.write    = req_write;
                st_d.wdata    = req_wdata;
                st_d.wait_n   = wait_states;
                st_d.lanesel  = req_lanesel;
                st_d.wide     = req_wide;
                st_d.rd_early = req_rd_early;
                st_d.acc      = '0;
            end
        end else begin
            if (cap) begin
                st_d.acc = acc_next;
            end
            if (st_q.tick == len_m1) begin
                st_d.tick = '0;
                if (st_q.beat == last_beat) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                end else begin
                    st_d.beat = st_q.beat + 2'd1;
                end
            end else begin
                st_d.tick = st_q.tick + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.active;
    assign done     = st_q.done;
    assign rdata    = st_q.acc;
    assign bus_addr = beat_addr;
    assign bus_dout = beat_dout;
    assign bus_doe  = rw_low | st_q.hold;

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_rd_n && bus_rw_n && bus_hstb_n && bus_lstb_n));

    p_basic_read_nosel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !st_q.lanesel && bus_rw_n) |-> (bus_hstb_n && bus_lstb_n));

    p_sel_with_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.lanesel && !bus_rd_n) |-> !(bus_hstb_n && bus_lstb_n));

    p_no_read_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rw_n |-> bus_rd_n);

    p_early_negate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.lanesel && st_q.tick == len_m1) |-> bus_rd_n);

    p_write_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_rw_n && !(st_q.tick == len_m1 && st_q.beat == last_beat)) |=> !bus_rw_n);

    p_oe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && bus_rw_n) |-> $past(!bus_rw_n));

    p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.size == SZ_BYTE) |-> (bus_hstb_n || bus_lstb_n));

    p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !st_q.wide) |-> bus_lstb_n);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

endmodule

// File: tb/sim_sram_bytesel_bus.sv
`timescale 1ns/1ps
module sim_sram_bytesel_bus;

    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  wait_states = '0;
    logic [7:0]  cfg_lanesel  = 8'b0101_1101;
    logic [7:0]  cfg_wide     = 8'b1111_0111;
    logic [7:0]  cfg_burst    = 8'b0000_0100;
    logic [7:0]  cfg_muxed    = 8'b0001_0000;
    logic [7:0]  cfg_rd_early = 8'b0110_0000;
    logic        busy, done, bus_doe, bus_rd_n, bus_rw_n, bus_hstb_n, bus_lstb_n;
    logic [31:0] rdata;
    logic [23:0] bus_addr;
    logic [15:0] bus_dout, bus_din;

    logic [7:0]  mem [256];
    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        logic [23:0] addr;
        bit          write;
        bit          hi, lo;
        logic [15:0] data;
        int          len;
        int          rd_last;
        int          slast;
        bit          any_strobe;
        bit          last;
        bit          lsel, ignored, narrow, waitnz;
        logic [31:0] rdata;
    } beat_t;

    beat_t exp_q[$];

    sram_bytesel_bus #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .wait_states(wait_states), .cfg_lanesel(cfg_lanesel), .cfg_wide(cfg_wide),
        .cfg_burst(cfg_burst), .cfg_muxed(cfg_muxed), .cfg_rd_early(cfg_rd_early),
        .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_rd_n(bus_rd_n), .bus_rw_n(bus_rw_n), .bus_hstb_n(bus_hstb_n),
        .bus_lstb_n(bus_lstb_n)
    );

    always #10 clk = ~clk;

    // RAM model: drives only while the read strobe is low.
    always_comb begin
        if (!bus_rd_n) begin
            if (cfg_wide[bus_addr[23:21]])
                bus_din = {mem[{bus_addr[7:1], 1'b0}], mem[{bus_addr[7:1], 1'b1}]};
            else
                bus_din = {mem[bus_addr[7:0]], 8'h00};
        end else begin
            bus_din = 16'hA5A5;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string strobe_tag(input beat_t e);
        if (e.lsel) return "R2";
        if (e.ignored) return "R1";
        return "R3";
    endfunction

    task automatic do_txn(input int area, input int offs, input int size, input bit wr,
                          input logic [31:0] wd, input int w, input bit poke);
        logic [23:0] a, base;
        bit          wide, lsel, early;
        int          nb, nbeats, len;
        logic [31:0] rexp;
        a     = {area[2:0], 21'(offs)};
        wide  = cfg_wide[area];
        lsel  = cfg_lanesel[area] && wide && !cfg_burst[area] && !cfg_muxed[area];
        early = lsel || cfg_rd_early[area];
        nb    = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        base  = (size == 0) ? a : {a[23:1], 1'b0};
        len   = 4 + 2 * w;
        rexp  = 0;
        for (int i = 0; i < nb; i++) rexp = (rexp << 8) | 32'(mem[8'(base + 24'(i))]);
        nbeats = wide ? ((size >= 2) ? 2 : 1) : nb;
        for (int b = 0; b < nbeats; b++) begin
            beat_t e;
            e.write = wr; e.len = len; e.rd_last = early ? len - 2 : len - 1;
            e.slast = lsel ? len - 1 : len - 2; e.any_strobe = lsel || wr;
            e.last = (b == nbeats - 1); e.lsel = lsel;
            e.ignored = cfg_lanesel[area] && !lsel; e.narrow = !wide;
            e.waitnz = (w != 0); e.rdata = rexp;
            if (wide) begin
                e.addr = base + 24'(2 * b);
                if (size == 0) begin
                    e.hi = !a[0]; e.lo = a[0]; e.data = {wd[7:0], wd[7:0]};
                end else begin
                    e.hi = 1; e.lo = 1;
                    e.data = (size == 1) ? wd[15:0] : (b == 0 ? wd[31:16] : wd[15:0]);
                end
            end else begin
                e.addr = base + 24'(b);
                e.hi = 1; e.lo = 0;
                e.data = {wd[8*(nb-1-b) +: 8], 8'h00};
            end
            exp_q.push_back(e);
        end
        @(negedge clk);
        req_addr = a; req_size = 2'(size); req_write = wr; req_wdata = wd;
        wait_states = 3'(w); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            req_addr = {3'd1, 21'h33}; req_size = 2'd0; req_write = 1'b0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R11", "request during busy ignored: busy", 32'(busy), 32'd0);
            end
        end
    endtask

    // Monitor: pops expected beats and compares every tick.
    initial begin
        forever begin
            @(negedge clk);
            if (busy === 1'b1 && exp_q.size() > 0) begin
                bit more, first;
                beat_t e;
                more = 1; first = 1;
                while (more) begin
                    e = exp_q.pop_front();
                    for (int t = 0; t < e.len; t++) begin
                        bit sact;
                        if (t > 0 || !first) @(negedge clk);
                        sact = e.any_strobe && t >= 1 && t <= e.slast;
                        chk("R11", "busy during beat", 32'(busy), 32'd1);
                        chk("R4", "rw_n", 32'(bus_rw_n), 32'(!e.write));
                        chk(e.waitnz ? "R8" : "R5", "rd_n",
                            32'(bus_rd_n), 32'(!(!e.write && t >= 1 && t <= e.rd_last)));
                        chk(strobe_tag(e), "hstb_n", 32'(bus_hstb_n), 32'(!(sact && e.hi)));
                        chk(e.narrow ? "R7" : "R6", "lstb_n", 32'(bus_lstb_n), 32'(!(sact && e.lo)));
                        chk(e.narrow ? "R7" : "R6", "addr", 32'(bus_addr), 32'(e.addr));
                        chk("R10", "doe", 32'(bus_doe), 32'(e.write));
                        if (e.write && e.hi) chk("R10", "dout hi", 32'(bus_dout[15:8]), 32'(e.data[15:8]));
                        if (e.write && e.lo) chk("R10", "dout lo", 32'(bus_dout[7:0]), 32'(e.data[7:0]));
                    end
                    first = 0;
                    more = !e.last;
                end
                @(negedge clk);
                chk("R11", "done pulse", 32'(done), 32'd1);
                chk("R11", "busy after end", 32'(busy), 32'd0);
                chk("R10", "doe hold", 32'(bus_doe), 32'(e.write));
                if (!e.write) chk("R9", "rdata", rdata, e.rdata);
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        chk("R12", "reset busy", 32'(busy), 0);
        chk("R12", "reset done", 32'(done), 0);
        chk("R12", "reset strobes", {28'd0, bus_rd_n, bus_rw_n, bus_hstb_n, bus_lstb_n}, 32'hF);
        chk("R12", "reset doe", 32'(bus_doe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "idle after reset", {28'd0, bus_rd_n, bus_rw_n, bus_hstb_n, bus_lstb_n}, 32'hF);

        do_txn(0, 'h10, 0, 0, 0, 0, 0);            // R2 even byte read
        do_txn(0, 'h11, 0, 0, 0, 0, 0);            // R6 odd byte read
        do_txn(0, 'h20, 1, 0, 0, 0, 0);            // R9 word read
        do_txn(0, 'h40, 2, 0, 0, 0, 0);            // R6 longword read
        do_txn(0, 'h31, 0, 1, 32'h5A, 0, 0);       // R2 byte write
        do_txn(0, 'h48, 2, 1, 32'h12345678, 2, 0); // R8 longword write
        do_txn(1, 'h22, 1, 0, 0, 0, 0);            // R3 basic read
        do_txn(1, 'h23, 0, 1, 32'hC3, 0, 0);       // R3 basic byte write
        do_txn(2, 'h24, 1, 0, 0, 0, 0);            // R1 burst area
        do_txn(3, 'h50, 2, 0, 0, 0, 0);            // R7 narrow longword read
        do_txn(3, 'h60, 1, 1, 32'hBEEF, 1, 0);     // R7 narrow word write
        do_txn(4, 'h13, 0, 0, 0, 0, 0);            // R1 multiplexed area
        do_txn(5, 'h26, 1, 0, 0, 0, 0);            // R5 basic early
        do_txn(6, 'h2A, 1, 0, 0, 3, 0);            // R5 lane-select with early bit
        do_txn(7, 'h44, 2, 1, 32'hCAFEF00D, 7, 1); // R11 poke while busy
        do_txn(0, 'h70, 1, 0, 0, 7, 0);            // R8 longest cycle

        repeat (4) @(negedge clk);
        chk("R11", "no leftover beats", 32'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule